// File: doc/BRIEF.md
# Fractional-Rate PTP Time Counter

This block keeps a 40-bit nanosecond time-of-day value with a 32-bit fraction of a nanosecond below it. When the timer is running, every clock tick adds a fixed base step of whole nanoseconds. On the same tick a signed rate trim goes into the fraction. A carry or borrow out of the fraction moves the nanosecond count by one extra nanosecond, up or down. Software sets the trim to pull the clock rate faster or slower without touching the base step.

Software reaches the counter through a 32-bit register port. Reads return data combinationally in the cycle of the read strobe. Reading the fraction word captures the whole nanosecond value, so the two nanosecond words read after it belong to the same instant. Writes are staged: the fraction word and the low nanosecond word wait in holding registers. Writing the high word loads all three at once.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the nanosecond value, the fraction and the rate trim are 0, and the control word reads 0x8000_0000 (bit 31 set, timer stopped).
- R2: While control bit 31 is 1 and no load occurs, the nanosecond value and the fraction do not change.
- R3: While running with a trim magnitude of 0, each tick adds exactly 8 ns and leaves the fraction unchanged.
- R4: With trim bit 31 = 0, each tick adds trim bits 30:0 to the fraction. A carry out of the 32-bit fraction adds 1 ns on that same tick, on top of the 8 ns step.
- R5: With trim bit 31 = 1, each tick subtracts trim bits 30:0 from the fraction. A borrow removes 1 ns from that tick's 8 ns step.
- R6: The nanosecond value is 40 bits wide and wraps modulo 2^40. The high word returns nanosecond bits 39:32 in bits 7:0, and bits 31:8 read as 0. On a write, only bits 7:0 of the high word are kept.
- R7: A read of address 0 returns the live fraction and captures the current nanosecond value. Reads of address 1 (bits 31:0) and address 2 (bits 39:32) return that captured value, not the live one.
- R8: The captured value stays unchanged, however much time passes and however often addresses 1 and 2 are read, until the next read of address 0 replaces it.
- R9: Writes to address 0 (fraction) and address 1 (nanosecond bits 31:0) only stage data and leave the running counter untouched. A write to address 2 loads the staged fraction, the staged low word and the written high bits together on one edge, and that edge applies no tick.
- R10: Address 3 holds the rate trim and address 4 holds the control word; both read back what was written. Writes to either take effect from the following tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick per rising edge while running |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register select: 0 fraction, 1 ns low, 2 ns high, 3 rate trim, 4 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register, valid in the same cycle |

## Verification
Assertions check four rules on every cycle:
- a stopped counter holds its value;
- an untrimmed tick moves it by exactly 8 ns;
- under a positive trim the extra nanosecond appears exactly when the fraction wraps upward, and under a negative trim the missing nanosecond appears exactly when it wraps downward;
- a high-word write loads the staged words in one step, and the captured snapshot only moves on a fraction read.

Only the bench scenarios can show whether the values seen through the register port are right. That covers absolute values after long runs under each trim sign, the 40-bit wrap with its zeroed reserved bits, a snapshot that goes stale against the live count, and staged writes that leave a running counter alone.

// File: rtl/ptc_pkg.sv
`timescale 1ns/1ps
package ptc_pkg;
  typedef enum logic [2:0] {
    A_FRAC  = 3'd0,
    A_NS_LO = 3'd1,
    A_NS_HI = 3'd2,
    A_RATE  = 3'd3,
    A_CTRL  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/ptc_tick_core.sv
`timescale 1ns/1ps
module ptc_tick_core #(
  parameter int NS_W    = 40,
  parameter int FRAC_W  = 32,
  parameter int STEP_NS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              rate_neg,
  input  logic [FRAC_W-2:0] rate_mag,
  input  logic              load_en,
  input  logic [NS_W-1:0]   load_ns,
  input  logic [FRAC_W-1:0] load_frac,
  output logic [NS_W-1:0]   ns_q,
  output logic [FRAC_W-1:0] frac_q
);
  // Fraction update: result bit FRAC_W is the carry (add) or borrow (sub).
  function automatic logic [FRAC_W:0] frac_adv(input logic [FRAC_W-1:0] f,
                                               input logic neg,
                                               input logic [FRAC_W-2:0] m);
    logic [FRAC_W:0] s;
    if (neg) s = {1'b0, f} - {2'b00, m};
    else     s = {1'b0, f} + {2'b00, m};
    return s;
  endfunction

  function automatic logic [NS_W-1:0] ns_adv(input logic [NS_W-1:0] n,
                                             input logic up, input logic down);
    return n + NS_W'(STEP_NS) + NS_W'(up) - NS_W'(down);
  endfunction

  logic [FRAC_W:0]   frac_sum;
  logic              frac_carry;
  logic              frac_borrow;
  logic [NS_W-1:0]   ns_nx;

  always_comb begin
    frac_sum    = frac_adv(frac_q, rate_neg, rate_mag);
    frac_carry  = frac_sum[FRAC_W] & ~rate_neg;
    frac_borrow = frac_sum[FRAC_W] & rate_neg;
    ns_nx       = ns_adv(ns_q, frac_carry, frac_borrow);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (load_en) begin
      ns_q   <= load_ns;
      frac_q <= load_frac;
    end else if (run) begin
      ns_q   <= ns_nx;
      frac_q <= frac_sum[FRAC_W-1:0];
    end
  end

  a_r2_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_en) |=> ($stable(ns_q) && $stable(frac_q)));

  a_r3_nominal_step: assert property (@(posedge clk) disable iff (rst)
    (run && !load_en && rate_mag == '0) |=>
      ((ns_q - $past(ns_q)) == NS_W'(STEP_NS) && $stable(frac_q)));

  a_r4_carry_adds_ns: assert property (@(posedge clk) disable iff (rst)
    (run && !load_en && !rate_neg && rate_mag != '0) |=>
      (((ns_q - $past(ns_q)) == NS_W'(STEP_NS + 1)) == (frac_q < $past(frac_q))));

  a_r5_borrow_drops_ns: assert property (@(posedge clk) disable iff (rst)
    (run && !load_en && rate_neg && rate_mag != '0) |=>
      (((ns_q - $past(ns_q)) == NS_W'(STEP_NS - 1)) == (frac_q > $past(frac_q))));

  a_r9_atomic_load: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (ns_q == $past(load_ns) && frac_q == $past(load_frac)));
endmodule

// File: rtl/ptc_snapshot.sv
`timescale 1ns/1ps
module ptc_snapshot #(
  parameter int NS_W = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap,
  input  logic            rel,
  input  logic [NS_W-1:0] live_ns,
  output logic [NS_W-1:0] snap_ns,
  output logic            snap_armed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_ns    <= '0;
      snap_armed <= 1'b0;
    end else if (cap) begin
      snap_ns    <= live_ns;
      snap_armed <= 1'b1;
    end else if (rel) begin
      snap_armed <= 1'b0;
    end
  end

  a_r7_capture: assert property (@(posedge clk) disable iff (rst)
    cap |=> (snap_ns == $past(live_ns) && snap_armed));

  a_r8_snap_hold: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(snap_ns));
endmodule

// File: rtl/ptc_stage.sv
`timescale 1ns/1ps
module ptc_stage #(
  parameter int FRAC_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_frac,
  input  logic              wr_lo,
  input  logic [DATA_W-1:0] wdata,
  output logic [FRAC_W-1:0] stage_frac,
  output logic [DATA_W-1:0] stage_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_frac <= '0;
      stage_lo   <= '0;
    end else begin
      if (wr_frac) stage_frac <= wdata[FRAC_W-1:0];
      if (wr_lo)   stage_lo   <= wdata;
    end
  end
endmodule

// File: rtl/ptp_time_counter.sv
`timescale 1ns/1ps
module ptp_time_counter #(
  parameter int NS_W    = 40,
  parameter int FRAC_W  = 32,
  parameter int STEP_NS = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  import ptc_pkg::*;

  localparam int HI_W = NS_W - DATA_W;

  logic              wr_frac, wr_lo, wr_hi, wr_rate, wr_ctrl, rd_frac, rd_hi;
  logic [FRAC_W-1:0] rate_q;
  logic              ctrl_off;
  logic [NS_W-1:0]   core_ns, snap_ns, load_ns;
  logic [FRAC_W-1:0] core_frac, stage_frac;
  logic [DATA_W-1:0] stage_lo;
  logic              snap_armed;

  assign wr_frac = bus_wr && bus_addr == A_FRAC;
  assign wr_lo   = bus_wr && bus_addr == A_NS_LO;
  assign wr_hi   = bus_wr && bus_addr == A_NS_HI;
  assign wr_rate = bus_wr && bus_addr == A_RATE;
  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign rd_frac = bus_rd && bus_addr == A_FRAC;
  assign rd_hi   = bus_rd && bus_addr == A_NS_HI;
  assign load_ns = {bus_wdata[HI_W-1:0], stage_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q   <= '0;
      ctrl_off <= 1'b1;
    end else begin
      if (wr_rate) rate_q   <= bus_wdata[FRAC_W-1:0];
      if (wr_ctrl) ctrl_off <= bus_wdata[DATA_W-1];
    end
  end

  ptc_tick_core #(.NS_W(NS_W), .FRAC_W(FRAC_W), .STEP_NS(STEP_NS)) u_core (
    .clk       (clk),
    .rst       (rst),
    .run       (!ctrl_off),
    .rate_neg  (rate_q[FRAC_W-1]),
    .rate_mag  (rate_q[FRAC_W-2:0]),
    .load_en   (wr_hi),
    .load_ns   (load_ns),
    .load_frac (stage_frac),
    .ns_q      (core_ns),
    .frac_q    (core_frac)
  );

  ptc_snapshot #(.NS_W(NS_W)) u_snap (
    .clk        (clk),
    .rst        (rst),
    .cap        (rd_frac),
    .rel        (rd_hi),
    .live_ns    (core_ns),
    .snap_ns    (snap_ns),
    .snap_armed (snap_armed)
  );

  ptc_stage #(.FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_stage (
    .clk        (clk),
    .rst        (rst),
    .wr_frac    (wr_frac),
    .wr_lo      (wr_lo),
    .wdata      (bus_wdata),
    .stage_frac (stage_frac),
    .stage_lo   (stage_lo)
  );

  always_comb begin
    case (bus_addr)
      A_FRAC:  bus_rdata = DATA_W'(core_frac);
      A_NS_LO: bus_rdata = snap_ns[DATA_W-1:0];
      A_NS_HI: bus_rdata = DATA_W'(snap_ns[NS_W-1:DATA_W]);
      A_RATE:  bus_rdata = DATA_W'(rate_q);
      A_CTRL:  bus_rdata = {ctrl_off, {(DATA_W-1){1'b0}}};
      default: bus_rdata = '0;
    endcase
  end

  a_r10_ctrl_applies: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (ctrl_off == $past(bus_wdata[DATA_W-1])));

  a_r8_armed_after_cap: assert property (@(posedge clk) disable iff (rst)
    (rd_frac && !wr_hi) |=> (snap_armed && snap_ns == $past(core_ns)));
endmodule

// File: tb/sim_ptp_time_counter.sv
`timescale 1ns/1ps
module sim_ptp_time_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ptp_time_counter u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Reference: time held as one 72-bit fixed-point number (ns.frac).
  logic [71:0] m_val;
  logic [31:0] m_rate, m_sf, m_sl;
  logic        m_off;
  logic [39:0] m_snap;

  always @(posedge clk) begin
    if (rst) begin
      m_val <= '0; m_rate <= '0; m_off <= 1'b1; m_sf <= '0; m_sl <= '0;
    end else begin
      if (bus_wr && bus_addr == 3'd3) m_rate <= bus_wdata;
      if (bus_wr && bus_addr == 3'd4) m_off  <= bus_wdata[31];
      if (bus_wr && bus_addr == 3'd0) m_sf   <= bus_wdata;
      if (bus_wr && bus_addr == 3'd1) m_sl   <= bus_wdata;
      if (bus_wr && bus_addr == 3'd2)
        m_val <= {bus_wdata[7:0], m_sl, m_sf};
      else if (!m_off) begin
        if (m_rate[31]) m_val <= m_val + (72'd8 << 32) - 72'(m_rate[30:0]);
        else            m_val <= m_val + (72'd8 << 32) + 72'(m_rate[30:0]);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic [71:0] mv);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1; d = bus_rdata; mv = m_val;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic rd_frac(input string tag, output logic [31:0] d);
    logic [71:0] mv;
    rd(3'd0, d, mv);
    chk(tag, d, mv[31:0]);
    m_snap = mv[71:32];
  endtask

  task automatic rd_lo(input string tag, output logic [31:0] d);
    logic [71:0] mv;
    rd(3'd1, d, mv);
    chk(tag, d, m_snap[31:0]);
  endtask

  task automatic rd_hi(input string tag, output logic [31:0] d);
    logic [71:0] mv;
    rd(3'd2, d, mv);
    chk(tag, d, {24'd0, m_snap[39:32]});
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [71:0] mv;
    rd(3'd4, d, mv); chk("R1 ctrl after reset", d, 32'h8000_0000);
    rd(3'd3, d, mv); chk("R1 rate after reset", d, 32'h0);
    rd_frac("R1 frac after reset", d); chk("R1 frac zero", d, 32'h0);
    rd_lo("R1 ns lo after reset", d);
    rd_hi("R1 ns hi after reset", d);
    idle(6);
    rd_frac("R2 frac while stopped", d); chk("R2 frac still zero", d, 32'h0);
    rd_lo("R2 ns lo while stopped", d); chk("R2 ns lo still zero", d, 32'h0);
  endtask

  task automatic t_nominal;
    logic [31:0] d;
    wr(3'd0, 32'h0000_0100);
    wr(3'd1, 32'h3456_7890);
    wr(3'd2, 32'h0000_0012);
    wr(3'd4, 32'h0);
    idle(10);
    rd_frac("R3 nominal frac", d); chk("R3 frac untouched", d, 32'h0000_0100);
    rd_lo("R3 nominal ns lo", d);
    rd_hi("R3 nominal ns hi", d);
    idle(7);
    rd_frac("R3 nominal frac later", d);
    rd_lo("R3 nominal ns lo later", d);
  endtask

  task automatic t_pos;
    logic [31:0] d; logic [71:0] mv;
    wr(3'd3, 32'h0800_0000);
    rd(3'd3, d, mv); chk("R10 rate readback", d, 32'h0800_0000);
    idle(45);
    rd_frac("R4 positive trim frac", d);
    rd_lo("R4 positive trim ns lo", d);
    wr(3'd3, 32'h7FFF_FFFF);
    idle(13);
    rd_frac("R4 large trim frac", d);
    rd_lo("R4 large trim ns lo", d);
    rd_hi("R4 large trim ns hi", d);
  endtask

  task automatic t_neg;
    logic [31:0] d;
    wr(3'd3, 32'hA000_0000);
    idle(23);
    rd_frac("R5 negative trim frac", d);
    rd_lo("R5 negative trim ns lo", d);
    rd_hi("R5 negative trim ns hi", d);
  endtask

  task automatic t_wrap;
    logic [31:0] d; logic [71:0] mv;
    wr(3'd4, 32'h8000_0000);
    rd(3'd4, d, mv); chk("R10 ctrl readback", d, 32'h8000_0000);
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'hFFFF_FFF0);
    wr(3'd2, 32'hABCD_EFFF);
    rd_frac("R6 frac after load", d);
    rd_hi("R6 hi keeps 8 bits", d); chk("R6 hi reserved zero", d, 32'h0000_00FF);
    wr(3'd4, 32'h0);
    idle(3);
    rd_frac("R6 frac after wrap", d);
    rd_lo("R6 ns lo after wrap", d);
    rd_hi("R6 ns hi after wrap", d); chk("R6 wrapped hi", d, 32'h0);
  endtask

  task automatic t_snap;
    logic [31:0] d, first_lo; logic [71:0] mv;
    wr(3'd3, 32'h0123_4567);
    rd_frac("R7 capture frac", d);
    idle(20);
    rd_lo("R7 ns lo from snapshot", first_lo);
    rd_hi("R7 ns hi from snapshot", d);
    idle(9);
    rd_lo("R8 ns lo held after hi read", d);
    rd(3'd1, d, mv);
    chk("R8 snapshot unchanged", d, first_lo);
    rd_frac("R8 re-arm frac", d);
    rd_lo("R8 ns lo new snapshot", d);
    rd_hi("R8 ns hi new snapshot", d);
  endtask

  task automatic t_stage;
    logic [31:0] d;
    wr(3'd0, 32'hDEAD_0000);
    wr(3'd1, 32'h0000_0005);
    idle(5);
    rd_frac("R9 staging leaves counter", d);
    rd_lo("R9 staging leaves ns lo", d);
    wr(3'd2, 32'h0000_0001);
    rd_frac("R9 loaded frac", d); chk("R9 frac loaded", d, 32'hDEAD_0000);
    rd_lo("R9 loaded ns lo", d); chk("R9 ns lo loaded", d, 32'h0000_0005);
    rd_hi("R9 loaded ns hi", d); chk("R9 ns hi loaded", d, 32'h0000_0001);
    idle(4);
    rd_frac("R9 runs on after load", d);
    rd_lo("R9 ns lo after load", d);
  endtask

  initial begin
    m_snap = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset;
    t_nominal;
    t_pos;
    t_neg;
    t_wrap;
    t_snap;
    t_stage;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule